// File: doc/BRIEF.md
# Execute Stage with Condition Flags

This block is the execute stage of a small 32-bit processor. It receives an instruction already decoded into an instruction class and a 4-bit function field, together with two operands: a source value and a destination value. It produces a result, a condition verdict and the current flag state. The same function field has two roles. For arithmetic/logic instructions it selects the ALU operation. For jumps and conditional moves it selects one of seven condition predicates.

Three flags are held in a register: zero, sign and overflow. Only a valid arithmetic/logic instruction with a legal function code writes this register, and the write happens on the rising clock edge. The result and the condition verdict are combinational outputs of the current inputs and the stored flags. The condition therefore reflects flags written by earlier instructions only.

The block accepts one instruction every cycle and never applies back-pressure, so the input has a valid qualifier and no ready signal. Downstream logic must take the result in the same cycle in which it is presented.

Top module: `exec_cc_unit`

## Requirements
- R1: After a synchronous active-low reset, the flag output `out_flags` is 3'b100: bit 2 is zero, bit 1 is sign and bit 0 is overflow.
- R2: When the class is 6, function 0 gives the result dst+src and function 1 gives dst-src, both modulo 2^32.
- R3: When the class is 6, function 2 gives the result dst AND src and function 3 gives dst XOR src.
- R4: A valid class-6 instruction with a function code from 0 to 3 writes the flags, and the new flags are visible after the next rising edge. Zero is set when the result is all zero. Sign equals bit 31 of the result.
- R5: Overflow is set on signed overflow of an add or a subtract, and is cleared by AND and XOR.
- R6: The flags keep their value when `in_valid` is low, and also when the class is not 6.
- R7: When the class is 7 (jump), `out_cond` evaluates the function code against the stored flags. Let lt = sign XOR overflow and le = lt OR zero. The codes are: 0 always, 1 le, 2 lt, 3 zero, 4 NOT zero, 5 NOT lt, 6 NOT le. The result is 0.
- R8: When the class is 2 (conditional move), `out_cond` uses the same predicate as R7 and the result equals src. Function 0 is the plain move and is always true.
- R9: Function codes above 6 for class 2 or 7, and above 3 for class 6, give `out_cond`=0 and a result of 0, and leave the flags unchanged.
- R10: When `in_valid` is low, or the class is any other value, the result is 0 and `out_cond` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_icode | input | 4 | Instruction class (2 move, 6 ALU, 7 jump) |
| in_fn | input | 4 | ALU operation or condition selector |
| in_src | input | 32 | Source operand |
| in_dst | input | 32 | Destination operand |
| out_result | output | 32 | Computed or forwarded value |
| out_cond | output | 1 | Condition verdict |
| out_flags | output | 3 | Stored flags {zero, sign, overflow} |

## Verification
The assertions assume that the class and function inputs are stable and known between clock edges. They also assume that a flag write is visible only from the cycle after it happens, so any check that relates the flags to an earlier result looks exactly one edge back. The stimulus changes inputs only on falling edges and holds them steady through each rising edge. It runs a sequence of instructions in which every condition is evaluated against flags written on purpose by the ALU instruction before it. That sequence covers each of the zero, sign and overflow combinations that the predicates distinguish.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [3:0] CLS_MOVE = 4'h2;
  localparam logic [3:0] CLS_ALU  = 4'h6;
  localparam logic [3:0] CLS_JUMP = 4'h7;

  localparam logic [3:0] ALU_LAST  = 4'h3;
  localparam logic [3:0] COND_LAST = 4'h6;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_XOR = 4'h3
  } alu_op_e;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'h0, C_LE = 4'h1, C_LT = 4'h2, C_EQ = 4'h3,
    C_NE = 4'h4, C_GE = 4'h5, C_GT = 4'h6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] res,
  output flags_t       flags_next,
  output logic         fn_ok
);
  localparam int MSB = W - 1;

  logic ovf;

  always_comb begin
    res   = '0;
    ovf   = 1'b0;
    fn_ok = (fn <= ALU_LAST);
    unique case (fn)
      OP_ADD: begin
        res = dst + src;
        ovf = (dst[MSB] == src[MSB]) && (res[MSB] != dst[MSB]);
      end
      OP_SUB: begin
        res = dst - src;
        ovf = (dst[MSB] != src[MSB]) && (res[MSB] != dst[MSB]);
      end
      OP_AND: res = dst & src;
      OP_XOR: res = dst ^ src;
      default: res = '0;
    endcase
    flags_next.zf = (res == '0);
    flags_next.sf = res[MSB];
    flags_next.of = ovf;
  end
endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] fn,
  output logic       taken,
  output logic       fn_ok
);
  logic lt, le;

  always_comb begin
    lt    = flags.sf ^ flags.of;
    le    = lt | flags.zf;
    fn_ok = (fn <= COND_LAST);
    unique case (fn)
      C_ALWAYS: taken = 1'b1;
      C_LE:     taken = le;
      C_LT:     taken = lt;
      C_EQ:     taken = flags.zf;
      C_NE:     taken = ~flags.zf;
      C_GE:     taken = ~lt;
      C_GT:     taken = ~le;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_ccreg.sv
module exu_ccreg
  import exu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= FLAGS_RESET;
    else if (load) q <= d;
  end
endmodule

// File: rtl/exec_cc_unit.sv
module exec_cc_unit
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   in_icode,
  input  logic [3:0]   in_fn,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_dst,
  output logic [W-1:0] out_result,
  output logic         out_cond,
  output logic [2:0]   out_flags
);
  logic [W-1:0] alu_res;
  flags_t       alu_flags, cur_flags;
  logic         alu_ok, cond_ok, cond_taken;
  logic         is_alu, is_move, is_jump, cc_load;

  exu_alu #(.W(W)) u_alu (
    .fn(in_fn), .src(in_src), .dst(in_dst),
    .res(alu_res), .flags_next(alu_flags), .fn_ok(alu_ok)
  );

  exu_cond u_cond (
    .flags(cur_flags), .fn(in_fn), .taken(cond_taken), .fn_ok(cond_ok)
  );

  exu_ccreg u_cc (
    .clk(clk), .rst_n(rst_n), .load(cc_load), .d(alu_flags), .q(cur_flags)
  );

  always_comb begin
    is_alu  = in_valid && (in_icode == CLS_ALU);
    is_move = in_valid && (in_icode == CLS_MOVE);
    is_jump = in_valid && (in_icode == CLS_JUMP);
    cc_load = is_alu && alu_ok;

    out_result = '0;
    out_cond   = 1'b0;
    if (cc_load) begin
      out_result = alu_res;
    end else if ((is_move || is_jump) && cond_ok) begin
      out_cond = cond_taken;
      if (is_move) out_result = in_src;
    end
  end

  assign out_flags = cur_flags;
endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   in_icode,
  input logic [3:0]   in_fn,
  input logic [W-1:0] out_result,
  input logic         out_cond,
  input logic [2:0]   out_flags
);
  logic alu_write;
  assign alu_write = in_valid && (in_icode == 4'h6) && (in_fn <= 4'h3);

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_write |=> $stable(out_flags));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alu_write |=> (out_flags[2] == ($past(out_result) == '0)));

  a_r4_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alu_write |=> (out_flags[1] == $past(out_result[W-1])));

  a_r5_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_write && in_fn[1]) |=> !out_flags[0]);

  a_r7_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_icode == 4'h7 || in_icode == 4'h2) && in_fn == 4'h0) |-> out_cond);

  a_r9_bad_fn_false: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fn > 4'h6) |-> (!out_cond && out_result == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!out_cond && out_result == '0));
endmodule

bind exec_cc_unit exu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_icode(in_icode),
  .in_fn(in_fn), .out_result(out_result), .out_cond(out_cond),
  .out_flags(out_flags)
);

// File: tb/exec_cc_unit_tb_top.sv
module exec_cc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_icode = '0;
  logic [3:0]  in_fn = '0;
  logic [31:0] in_src = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] out_result;
  logic        out_cond;
  logic [2:0]  out_flags;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  exec_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_icode(in_icode),
    .in_fn(in_fn), .in_src(in_src), .in_dst(in_dst),
    .out_result(out_result), .out_cond(out_cond), .out_flags(out_flags)
  );

  // {req, icode, fn, src, dst, exp_result, exp_cond, exp_flags_after}
  localparam int NV = 24;
  localparam logic [111:0] VEC [NV] = '{
    {4'd7,  4'h7, 4'h3, 32'h0, 32'h0, 32'h0, 1'b1, 3'b100},                   // R7 je after reset
    {4'd7,  4'h7, 4'h4, 32'h0, 32'h0, 32'h0, 1'b0, 3'b100},                   // R7 jne
    {4'd2,  4'h6, 4'h0, 32'd5, 32'd7, 32'd12, 1'b0, 3'b000},                  // R2 add
    {4'd7,  4'h7, 4'h4, 32'h0, 32'h0, 32'h0, 1'b1, 3'b000},                   // R7 jne
    {4'd7,  4'h7, 4'h6, 32'h0, 32'h0, 32'h0, 1'b1, 3'b000},                   // R7 jg
    {4'd2,  4'h6, 4'h1, 32'd7, 32'd5, 32'hFFFF_FFFE, 1'b0, 3'b010},           // R2 sub dst-src
    {4'd7,  4'h7, 4'h2, 32'h0, 32'h0, 32'h0, 1'b1, 3'b010},                   // R7 jl
    {4'd8,  4'h2, 4'h1, 32'h1234, 32'h0, 32'h1234, 1'b1, 3'b010},             // R8 cmovle
    {4'd8,  4'h2, 4'h5, 32'h1234, 32'h0, 32'h1234, 1'b0, 3'b010},             // R8 cmovge
    {4'd5,  4'h6, 4'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 3'b011},   // R5 add ovf
    {4'd7,  4'h7, 4'h2, 32'h0, 32'h0, 32'h0, 1'b0, 3'b011},                   // R7 jl S^O=0
    {4'd7,  4'h7, 4'h5, 32'h0, 32'h0, 32'h0, 1'b1, 3'b011},                   // R7 jge
    {4'd5,  4'h6, 4'h1, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 3'b001},   // R5 sub ovf
    {4'd7,  4'h7, 4'h2, 32'h0, 32'h0, 32'h0, 1'b1, 3'b001},                   // R7 jl O only
    {4'd3,  4'h6, 4'h2, 32'h0000_F0F0, 32'h0000_0FF0, 32'h0000_00F0, 1'b0, 3'b000}, // R3 and
    {4'd3,  4'h6, 4'h3, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0, 1'b0, 3'b100},   // R3 xor zero
    {4'd7,  4'h7, 4'h3, 32'h0, 32'h0, 32'h0, 1'b1, 3'b100},                   // R7 je
    {4'd9,  4'h6, 4'h4, 32'h1, 32'h2, 32'h0, 1'b0, 3'b100},                   // R9 bad alu fn
    {4'd4,  4'h6, 4'h3, 32'h8000_0000, 32'h0, 32'h8000_0000, 1'b0, 3'b010},   // R4 sign
    {4'd9,  4'h7, 4'h7, 32'h5, 32'h5, 32'h0, 1'b0, 3'b010},                   // R9 bad jump fn
    {4'd8,  4'h2, 4'h0, 32'hABCD, 32'h0, 32'hABCD, 1'b1, 3'b010},             // R8 plain move
    {4'd7,  4'h7, 4'h0, 32'h0, 32'h0, 32'h0, 1'b1, 3'b010},                   // R7 jmp
    {4'd10, 4'h3, 4'h0, 32'h1, 32'h1, 32'h0, 1'b0, 3'b010},                   // R10 other class
    {4'd5,  4'h6, 4'h0, 32'h1, 32'hFFFF_FFFF, 32'h0, 1'b0, 3'b100}            // R5 carry, no ovf
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] ic, input logic [3:0] f,
                       input logic [31:0] s, input logic [31:0] d);
    in_valid = v; in_icode = ic; in_fn = f; in_src = s; in_dst = d;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "flags after reset", {29'b0, out_flags}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][111:108]);
      drive(1'b1, VEC[i][107:104], VEC[i][103:100], VEC[i][99:68], VEC[i][67:36]);
      #5;
      check(rq, $sformatf("result v%0d", i), out_result, VEC[i][35:4]);
      check(rq, $sformatf("cond v%0d", i), {31'b0, out_cond}, {31'b0, VEC[i][3]});
      @(negedge clk);
      check(rq, $sformatf("flags v%0d", i), {29'b0, out_flags}, {29'b0, VEC[i][2:0]});
    end

    // R10 / R6: invalid ALU instruction changes nothing
    drive(1'b0, 4'h6, 4'h0, 32'h1, 32'h1);
    #5;
    check("R10", "idle result", out_result, 32'h0);
    check("R10", "idle cond", {31'b0, out_cond}, 32'h0);
    @(negedge clk);
    check("R6", "flags held when invalid", {29'b0, out_flags}, 32'h4);

    // R1: reset from a non-reset flag state
    drive(1'b1, 4'h6, 4'h0, 32'h1, 32'h1);
    @(negedge clk);
    check("R4", "flags after 1+1", {29'b0, out_flags}, 32'h0);
    drive(1'b0, 4'h0, 4'h0, 32'h0, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "flags after mid-run reset", {29'b0, out_flags}, 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule